// File: doc/BRIEF.md
# Guarded-Reload Watchdog Timer

This block is a watchdog that resets the system when software stops servicing it. A fixed clock-enable divider and a binary prescaler form a slow tick, and an up-counter advances on that tick. When the counter wraps from its all-ones value to zero, the block drives its reset output for a fixed number of clock cycles. While that pulse is active, all internal state is held cleared.

Software keeps the system alive by reloading the counter before it wraps. A reload only counts when software has first armed a permission flag in the control register. The accepted load clears that flag and restarts the prescaler, so each reload needs a new arming write. Stray writes to the counter therefore have no effect.

An active-low enable pin starts the watchdog. The same pin vetoes the power-down request bit of the control register. An idle-mode input is accepted and has no effect, so the watchdog keeps running in idle.

Top module: `wdg_guarded_top`

## Requirements
- R1: After the asynchronous power-on reset, the following all read 0: the counter readback, every control readback bit and the reset output.
- R2: While the enable pin is low and no reset pulse is active, the counter advances by one every DIV_PRE × 2^PRESC_W clock cycles.
- R3: A write with `wr_sel`=1 while the permission flag (control bit 4) is 0 leaves the counter unchanged.
- R4: A control write (`wr_sel`=0) sets the permission flag when data bit 4 is 1 and clears it when data bit 4 is 0. The write does not change the counter value.
- R5: A counter write made while the flag is 1 loads the low CNT_W data bits into the counter, clears the flag and clears the prescaler. The next increment then comes at most DIV_PRE × 2^PRESC_W cycles later and more than DIV_PRE × (2^PRESC_W − 1) cycles later.
- R6: When the counter wraps from all ones to 0, `wdt_rst_o` goes high on the next cycle and stays high for exactly PULSE_LEN cycles.
- R7: While `wdt_rst_o` is high, the counter, the flag and the power-down bit read 0, and all writes are ignored.
- R8: While the enable pin is high, the counter holds its value and a control write with data bit 1 set makes control bit 1 (power-down) read 1.
- R9: While the enable pin is low, control bit 1 reads 0, and a power-down write made then does not set the bit.
- R10: The idle input has no effect on counting or on the outputs.
- R11: When a counter write and a wrap fall in the same cycle, the wrap wins: the reset pulse starts and the counter reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control register, 1 counter |
| wr_data | input | DATA_W | Write data |
| guard_en_n | input | 1 | Enable pin: low runs the watchdog and blocks power-down |
| idle_i | input | 1 | Idle-mode indication, has no effect |
| cnt_rd | output | CNT_W | Counter readback |
| ctrl_rd | output | DATA_W | Control readback: bit 4 permission flag, bit 1 power-down, other bits 0 |
| wdt_rst_o | output | 1 | Watchdog reset pulse |

## Verification
If the divider or prescaler phase is wrong, the counter steps at the wrong cycle. This shows on `cnt_rd` within one tick period, and the reset pulse then starts early or late. A permission flag that stays set after a load shows on `ctrl_rd` bit 4 one cycle after the load, and it also lets a second unarmed write change the counter. A wrong pulse stretcher shows as a wrong `wdt_rst_o` width, or as nonzero readbacks during the pulse, within PULSE_LEN cycles of the wrap.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   typedef enum logic {
      SEL_CTRL  = 1'b0,
      SEL_COUNT = 1'b1
   } wdg_sel_e;

   function automatic int unsigned wdg_cw(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen #(
   parameter int unsigned DIV_PRE  = 12,
   parameter int unsigned PRESC_W  = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic hold,
   input  logic presc_clr,
   output logic carry
);
   localparam int unsigned DIV_W = wdg_pkg::wdg_cw(DIV_PRE);

   logic             div_tick;
   logic [PRESC_W-1:0] presc_q;

   generate
      if (DIV_PRE == 1) begin : g_nodiv
         assign div_tick = run;
      end else begin : g_div
         logic [DIV_W-1:0] div_q;
         localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_PRE - 1);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               div_q <= '0;
            else if (hold)
               div_q <= '0;
            else if (run)
               div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
         end
         assign div_tick = run && (div_q == DIV_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         presc_q <= '0;
      else if (hold || presc_clr)
         presc_q <= '0;
      else if (div_tick)
         presc_q <= presc_q + 1'b1;
   end

   assign carry = div_tick && (&presc_q);

endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              carry,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              ovf
);
   assign ovf = carry && (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (hold || ovf)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val[CNT_W-1:0];
      else if (carry)
         cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned PERM_BIT = 4,
   parameter int unsigned PD_BIT   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pin_high,
   output logic              perm_q,
   output logic [DATA_W-1:0] rd
);
   logic pd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         perm_q <= 1'b0;
         pd_q   <= 1'b0;
      end else if (clr) begin
         perm_q <= 1'b0;
         pd_q   <= 1'b0;
      end else if (load) begin
         perm_q <= 1'b0;
      end else if (we) begin
         perm_q <= wdata[PERM_BIT];
         pd_q   <= wdata[PD_BIT] && pin_high;
      end
   end

   always_comb begin
      rd           = '0;
      rd[PERM_BIT] = perm_q;
      rd[PD_BIT]   = pd_q && pin_high;
   end

endmodule

// File: rtl/wdg_stretch.sv
module wdg_stretch #(
   parameter int unsigned PULSE_LEN = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic busy
);
   localparam int unsigned PW = wdg_pkg::wdg_cw(PULSE_LEN);
   localparam logic [PW-1:0] LEN = PW'(PULSE_LEN);

   logic [PW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         left_q <= '0;
      else if (trig)
         left_q <= LEN;
      else if (left_q != '0)
         left_q <= left_q - 1'b1;
   end

   assign busy = (left_q != '0);

endmodule

// File: rtl/wdg_guarded_top.sv
module wdg_guarded_top #(
   parameter int unsigned DIV_PRE   = 12,
   parameter int unsigned PRESC_W   = 11,
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned PULSE_LEN = 24,
   parameter int unsigned PERM_BIT  = 4,
   parameter int unsigned PD_BIT    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              guard_en_n,
   input  logic              idle_i,
   output logic [CNT_W-1:0]  cnt_rd,
   output logic [DATA_W-1:0] ctrl_rd,
   output logic              wdt_rst_o
);
   import wdg_pkg::*;

   generate
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must be in 1..DATA_W");
      end
      if (PRESC_W < 1) begin : g_bad_pre
         $error("PRESC_W must be at least 1");
      end
      if (DIV_PRE < 1 || PULSE_LEN < 1) begin : g_bad_div
         $error("DIV_PRE and PULSE_LEN must be at least 1");
      end
      if (PERM_BIT >= DATA_W || PD_BIT >= DATA_W || PERM_BIT == PD_BIT) begin : g_bad_bits
         $error("control bit positions invalid");
      end
   endgenerate

   logic run_w, hold_w, carry_w, ovf_w, load_w, ctrl_we_w, perm_w, idle_unused;

   assign idle_unused = idle_i;
   assign run_w     = !guard_en_n && !hold_w;
   assign load_w    = wr_en && (wr_sel == SEL_COUNT) && perm_w && !ovf_w && !hold_w;
   assign ctrl_we_w = wr_en && (wr_sel == SEL_CTRL) && !hold_w;

   wdg_tick_gen #(.DIV_PRE(DIV_PRE), .PRESC_W(PRESC_W)) tick_i (
      .clk(clk), .rst_n(rst_n), .run(run_w), .hold(hold_w),
      .presc_clr(ovf_w || load_w), .carry(carry_w));

   wdg_count #(.CNT_W(CNT_W), .DATA_W(DATA_W)) count_i (
      .clk(clk), .rst_n(rst_n), .hold(hold_w), .carry(carry_w),
      .load(load_w), .load_val(wr_data), .cnt_q(cnt_rd), .ovf(ovf_w));

   wdg_ctrl #(.DATA_W(DATA_W), .PERM_BIT(PERM_BIT), .PD_BIT(PD_BIT)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .clr(hold_w || ovf_w), .load(load_w),
      .we(ctrl_we_w), .wdata(wr_data), .pin_high(guard_en_n),
      .perm_q(perm_w), .rd(ctrl_rd));

   wdg_stretch #(.PULSE_LEN(PULSE_LEN)) stretch_i (
      .clk(clk), .rst_n(rst_n), .trig(ovf_w), .busy(hold_w));

   assign wdt_rst_o = hold_w;

endmodule

// File: rtl/wdg_guarded_chk.sv
module wdg_guarded_chk #(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned PULSE_LEN = 24,
   parameter int unsigned PERM_BIT  = 4,
   parameter int unsigned PD_BIT    = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_sel,
   input logic [DATA_W-1:0] wr_data,
   input logic              guard_en_n,
   input logic [CNT_W-1:0]  cnt_rd,
   input logic [DATA_W-1:0] ctrl_rd,
   input logic              wdt_rst_o,
   input logic              carry,
   input logic              ovf
);
   logic [15:0] hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hi_q <= '0;
      else if (wdt_rst_o)
         hi_q <= hi_q + 1'b1;
      else
         hi_q <= '0;
   end

   // R3
   no_unarmed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && !ctrl_rd[PERM_BIT] && !wdt_rst_o && !carry) |=> $stable(cnt_rd));

   // R5
   armed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && ctrl_rd[PERM_BIT] && !wdt_rst_o && !ovf)
      |=> (!ctrl_rd[PERM_BIT] && cnt_rd == $past(wr_data[CNT_W-1:0])));

   // R6
   ovf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (wdt_rst_o && cnt_rd == '0));

   // R6
   pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdt_rst_o) |-> (hi_q == 16'(PULSE_LEN)));

   // R7
   pulse_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_o |-> (cnt_rd == '0 && !ctrl_rd[PERM_BIT] && !ctrl_rd[PD_BIT]));

   // R9
   pd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && !guard_en_n) |=> !ctrl_rd[PD_BIT]);

endmodule

bind wdg_guarded_top wdg_guarded_chk #(
   .CNT_W(CNT_W), .DATA_W(DATA_W), .PULSE_LEN(PULSE_LEN),
   .PERM_BIT(PERM_BIT), .PD_BIT(PD_BIT)
) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
   .guard_en_n(guard_en_n), .cnt_rd(cnt_rd), .ctrl_rd(ctrl_rd),
   .wdt_rst_o(wdt_rst_o), .carry(carry_w), .ovf(ovf_w));

// File: tb/wdg_guarded_top_tb.sv
`timescale 1ns/1ps
module wdg_guarded_top_tb_top;
   localparam int DIV   = 3;
   localparam int PW    = 2;
   localparam int CW    = 4;
   localparam int DW    = 8;
   localparam int PULSE = 5;
   localparam int PMAX  = (1 << PW) - 1;
   localparam int CMAX  = (1 << CW) - 1;
   localparam int TICK  = DIV * (PMAX + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic wr_sel = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic pin_n = 1'b0;
   logic idle = 1'b0;
   logic [CW-1:0] cnt_rd;
   logic [DW-1:0] ctrl_rd;
   logic rst_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int m_div = 0, m_pre = 0, m_cnt = 0, m_pulse = 0;
   bit m_perm = 1'b0, m_pd = 1'b0;

   always #2.5 clk = ~clk;

   wdg_guarded_top #(.DIV_PRE(DIV), .PRESC_W(PW), .CNT_W(CW), .DATA_W(DW),
      .PULSE_LEN(PULSE), .PERM_BIT(4), .PD_BIT(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .guard_en_n(pin_n), .idle_i(idle), .cnt_rd(cnt_rd), .ctrl_rd(ctrl_rd),
      .wdt_rst_o(rst_o));

   function automatic int exp_ctrl();
      return (int'(m_perm) << 4) | (int'(m_pd && pin_n) << 1);
   endfunction

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   function automatic bit ovf_next();
      return !pin_n && m_pulse == 0 && m_div == DIV-1 && m_pre == PMAX && m_cnt == CMAX;
   endfunction

   task automatic cyc();
      int n_div, n_pre, n_cnt, n_pulse;
      bit n_perm, n_pd, en, busy, dtick, carry, ovf, load, cw;
      en    = !pin_n;
      busy  = (m_pulse != 0);
      dtick = en && !busy && m_div == DIV-1;
      carry = dtick && m_pre == PMAX;
      ovf   = carry && m_cnt == CMAX;
      load  = wr_en && wr_sel && m_perm && !ovf && !busy;
      cw    = wr_en && !wr_sel && !busy;
      n_pulse = ovf ? PULSE : (busy ? m_pulse - 1 : 0);
      n_div   = busy ? 0 : (en ? ((m_div == DIV-1) ? 0 : m_div + 1) : m_div);
      n_pre   = (busy || ovf || load) ? 0 : (dtick ? (m_pre + 1) % (PMAX + 1) : m_pre);
      n_cnt   = (busy || ovf) ? 0 : (load ? int'(wr_data) % (CMAX + 1) :
                (carry ? m_cnt + 1 : m_cnt));
      n_perm  = (busy || ovf || load) ? 1'b0 : (cw ? wr_data[4] : m_perm);
      n_pd    = (busy || ovf) ? 1'b0 : (cw ? (wr_data[1] && pin_n) : m_pd);
      @(posedge clk);
      if (!rst_n) begin
         m_div = 0; m_pre = 0; m_cnt = 0; m_pulse = 0; m_perm = 0; m_pd = 0;
      end else begin
         m_div = n_div; m_pre = n_pre; m_cnt = n_cnt; m_pulse = n_pulse;
         m_perm = n_perm; m_pd = n_pd;
      end
      #1;
      chk("R2 R3 R5 R7 R8 R10 R11 count", int'(cnt_rd), m_cnt);
      chk("R4 R5 R7 R8 R9 ctrl", int'(ctrl_rd), exp_ctrl());
      chk("R6 R7 R11 reset out", int'(rst_o), int'(m_pulse != 0));
   endtask

   task automatic wr(input bit sel, input int data);
      wr_en = 1'b1; wr_sel = sel; wr_data = DW'(data);
      cyc();
      wr_en = 1'b0;
   endtask

   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   initial begin
      int n, v;
      void'($urandom(32'd4242));
      // R1
      rst_n = 1'b0;
      idle_cycles(3);
      chk("R1 count", int'(cnt_rd), 0);
      chk("R1 ctrl", int'(ctrl_rd), 0);
      chk("R1 reset out", int'(rst_o), 0);
      rst_n = 1'b1;
      idle_cycles(1);

      // R3: unarmed counter write ignored
      wr(1'b1, 9);
      chk("R3 unarmed write", int'(cnt_rd), 0);

      // R4: arm, disarm, re-arm; counter untouched
      wr(1'b0, 8'h10);
      chk("R4 flag set", int'(ctrl_rd[4]), 1);
      wr(1'b0, 8'h00);
      chk("R4 flag clear", int'(ctrl_rd[4]), 0);
      v = int'(cnt_rd);
      wr(1'b0, 8'h10);
      chk("R4 counter kept", int'(cnt_rd), v);

      // R5: armed load
      wr(1'b1, 5);
      chk("R5 load value", int'(cnt_rd), 5);
      chk("R5 flag auto clear", int'(ctrl_rd[4]), 0);
      n = 0;
      while (cnt_rd == CW'(5) && n < 4 * TICK) begin cyc(); n++; end
      chk("R5 restart upper", int'(n <= TICK), 1);
      chk("R5 restart lower", int'(n > DIV * PMAX), 1);

      // R2 and R10: steady period, idle asserted
      idle = 1'b1;
      v = int'(cnt_rd);
      n = 0;
      while (int'(cnt_rd) == v && n < 4 * TICK) begin cyc(); n++; end
      chk("R2 R10 tick period", n, TICK);
      idle = 1'b0;

      // R9: power-down blocked while enabled
      wr(1'b0, 8'h02);
      chk("R9 pd reads 0", int'(ctrl_rd[1]), 0);
      pin_n = 1'b1;
      idle_cycles(1);
      chk("R9 pd not stored", int'(ctrl_rd[1]), 0);

      // R8: disabled, counter frozen, pd settable
      v = int'(cnt_rd);
      wr(1'b0, 8'h02);
      chk("R8 pd set", int'(ctrl_rd[1]), 1);
      idle_cycles(5 * TICK);
      chk("R8 counter frozen", int'(cnt_rd), v);
      pin_n = 1'b0;
      idle_cycles(1);
      chk("R9 pd masked", int'(ctrl_rd[1]), 0);

      // R6 R7: overflow pulse
      wr(1'b0, 8'h10);
      wr(1'b1, CMAX);
      n = 0;
      while (!rst_o && n < 4 * TICK) begin cyc(); n++; end
      chk("R6 pulse starts", int'(rst_o), 1);
      wr(1'b0, 8'h12);
      chk("R7 ctrl ignored in pulse", int'(ctrl_rd), 0);
      wr(1'b1, 7);
      chk("R7 count ignored in pulse", int'(cnt_rd), 0);
      n = 2;
      while (rst_o && n < 4 * PULSE) begin cyc(); n++; end
      chk("R6 pulse width", n, PULSE);

      // R11: collision of counter write and wrap
      wr(1'b0, 8'h10);
      wr(1'b1, CMAX);
      wr(1'b0, 8'h10);
      n = 0;
      while (!ovf_next() && n < 4 * TICK) begin cyc(); n++; end
      wr(1'b1, 3);
      chk("R11 wrap wins pulse", int'(rst_o), 1);
      chk("R11 wrap wins count", int'(cnt_rd), 0);
      idle_cycles(PULSE + 2);

      // random phase
      for (int i = 0; i < 6000; i++) begin
         int r;
         r = int'($urandom_range(0, 99));
         idle = $urandom_range(0, 1) == 1;
         if (r < 2) pin_n = ~pin_n;
         if (r >= 90) begin
            wr_en = 1'b1; wr_sel = 1'b0;
            wr_data = DW'($urandom_range(0, 255));
         end else if (r >= 85) begin
            wr_en = 1'b1; wr_sel = 1'b1;
            wr_data = DW'($urandom_range(0, 255));
         end else begin
            wr_en = 1'b0;
         end
         cyc();
         wr_en = 1'b0;
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(5ns * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got hang expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule